// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

This block is one 16-bit counting channel that produces timed events. Software programs it through a small register bank. The bank holds a control word, a mode word, three compare values, sticky status flags and an interrupt mask. A separate tick input advances the counter by one step for each pulse while the channel is clocked and started.

When the count meets a compare value, the block raises a status flag. It can also change the level of a waveform pin, and a match on the third compare value can reset, stop or switch off the counter. Software uses it in two ways:

- **Periodic interval:** auto-reset on the third compare value, with the period held in that register.
- **One-shot:** write the delay, then issue clock-enable together with a software trigger. The channel counts once up to the match and then halts.

The interrupt line is the OR of the status flags that the mask lets through. The register bank answers only when the address selects this channel's bank.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset the count is 0, the pin is 0, the interrupt is low, the clock is off, the channel is not started, and the mode, compare, status and mask registers all read 0.
- R2: A write to offset 0x00 uses bit 0 to switch the clock on and bit 1 to switch it off. When both bits are set, off wins. Status bit 16 reads 1 while the clock is on.
- R3: Bit 2 of a write to offset 0x00 clears the count to 0 and starts the channel. The count then rises by one on each cycle with tick high, but only while the clock is on and the channel is started. A trigger in the same cycle as a tick takes precedence over that tick.
- R4: Mode bit 14 (wave codes 2 and 3 in bits 14:13) selects auto-reset. On a counting tick while the count equals compare C (offset 0x1c), the count returns to 0. Without auto-reset the count wraps from 0xFFFF to 0, and that wrap sets status bit 0.
- R5: Mode bit 6 makes a counting tick at a C match stop the channel while the clock stays on. Mode bit 7 also switches the clock off at that match.
- R6: Mode bits 17:16 give the pin action on an A match (offset 0x14), and bits 19:18 give the action on a C match. The codes are 0 none, 1 set, 2 clear and 3 toggle. When A and C match on the same tick, the C action applies. Status bit 17 mirrors the pin.
- R7: On a counting tick, status bits 2, 3 and 4 latch A, B (offset 0x18) and C matches against the count held before that tick. A read of offset 0x20 returns the status and clears bits 0, 2, 3 and 4. A flag set on the same edge as that read survives.
- R8: A write to offset 0x24 sets mask bits and a write to offset 0x28 clears them, for bits 0, 2, 3 and 4. Offset 0x2c reads the mask back. The interrupt is high when any status flag has its mask bit set.
- R9: Address bits 7:6 must equal the channel index (default 0) for an access to act. Other accesses change nothing, return 0 and clear nothing.
- R10: Read data appears on the cycle after a read strobe and holds until the next read. The bank reads back as follows:
  - Offset 0x10 returns the count.
  - The mode word returns only bits 6, 7, 14 and 19:16.
  - Offsets 0x00, 0x24, 0x28 and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address; upper bits select the channel bank |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| tick | input | 1 | Count-enable pulse |
| count_val | output | CNT_W | Current count |
| tioa_o | output | 1 | Waveform pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The counting function is driven four ways:
- **Random mix:** sparse ticks interleaved with random register traffic and small compare values. This separates the compare-before-increment timing from a compare-after variant, and shows whether a trigger overrides a same-cycle tick.
- **Directed one-shot runs:** these tell the stop-only halt apart from the switch-off halt through the clock bit in status.
- **Free-running sweep past 0xFFFF:** the only pattern that shows the wrap and its overflow flag.
- **Equal A and C values under opposing pin actions:** this exposes the priority between the two actions, and foreign-bank writes show that the decode isolates the channel.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int BANK_LSB = 6;

  localparam logic [BANK_LSB-1:0] OFS_CTRL = 6'h00;
  localparam logic [BANK_LSB-1:0] OFS_MODE = 6'h04;
  localparam logic [BANK_LSB-1:0] OFS_CNT  = 6'h10;
  localparam logic [BANK_LSB-1:0] OFS_CMPA = 6'h14;
  localparam logic [BANK_LSB-1:0] OFS_CMPB = 6'h18;
  localparam logic [BANK_LSB-1:0] OFS_CMPC = 6'h1c;
  localparam logic [BANK_LSB-1:0] OFS_STAT = 6'h20;
  localparam logic [BANK_LSB-1:0] OFS_IEN  = 6'h24;
  localparam logic [BANK_LSB-1:0] OFS_IDIS = 6'h28;
  localparam logic [BANK_LSB-1:0] OFS_IMSK = 6'h2c;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_e;

  typedef struct packed {
    logic     stop_on_c;
    logic     dis_on_c;
    logic     auto_rst;
    pin_act_e act_a;
    pin_act_e act_c;
  } mode_t;

  typedef struct packed {
    logic ovf;
    logic cmp_a;
    logic cmp_b;
    logic cmp_c;
  } evt_t;

  function automatic logic apply_act(input pin_act_e act, input logic cur);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CHAN_IDX = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  evt_t                  evt,
  input  logic                  clk_on,
  input  logic                  pin,
  input  logic [CNT_W-1:0]      cnt,
  output mode_t                 mode,
  output logic [2:0][CNT_W-1:0] cmp_vals,
  output logic                  ctl_en,
  output logic                  ctl_dis,
  output logic                  ctl_trg,
  output logic                  irq
);
  localparam int BANK_W = ADDR_W - BANK_LSB;
  localparam logic [BANK_W-1:0] BANK_ID = BANK_W'(CHAN_IDX);

  logic                 sel;
  logic [BANK_LSB-1:0]  ofs;
  logic                 wr_hit, rd_hit;
  evt_t                 sts_q, msk_q, wmask;
  logic [DATA_W-1:0]    rd_mux;

  assign sel    = (reg_addr[ADDR_W-1:BANK_LSB] == BANK_ID);
  assign ofs    = reg_addr[BANK_LSB-1:0];
  assign wr_hit = reg_wr && sel;
  assign rd_hit = reg_rd && sel;

  assign ctl_en  = wr_hit && (ofs == OFS_CTRL) && reg_wdata[0];
  assign ctl_dis = wr_hit && (ofs == OFS_CTRL) && reg_wdata[1];
  assign ctl_trg = wr_hit && (ofs == OFS_CTRL) && reg_wdata[2];

  assign wmask = '{ovf: reg_wdata[0], cmp_a: reg_wdata[2],
                   cmp_b: reg_wdata[3], cmp_c: reg_wdata[4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      cmp_vals <= '0;
      msk_q    <= '0;
    end else if (wr_hit) begin
      case (ofs)
        OFS_MODE: begin
          mode.stop_on_c <= reg_wdata[6];
          mode.dis_on_c  <= reg_wdata[7];
          mode.auto_rst  <= reg_wdata[14];
          mode.act_a     <= pin_act_e'(reg_wdata[17:16]);
          mode.act_c     <= pin_act_e'(reg_wdata[19:18]);
        end
        OFS_CMPA: cmp_vals[0] <= reg_wdata[CNT_W-1:0];
        OFS_CMPB: cmp_vals[1] <= reg_wdata[CNT_W-1:0];
        OFS_CMPC: cmp_vals[2] <= reg_wdata[CNT_W-1:0];
        OFS_IEN:  msk_q <= msk_q | wmask;
        OFS_IDIS: msk_q <= msk_q & ~wmask;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (rd_hit && (ofs == OFS_STAT)) begin
      sts_q <= evt;
    end else begin
      sts_q <= sts_q | evt;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel) begin
      case (ofs)
        OFS_MODE: begin
          rd_mux[6]     = mode.stop_on_c;
          rd_mux[7]     = mode.dis_on_c;
          rd_mux[14]    = mode.auto_rst;
          rd_mux[17:16] = mode.act_a;
          rd_mux[19:18] = mode.act_c;
        end
        OFS_CNT:  rd_mux[CNT_W-1:0] = cnt;
        OFS_CMPA: rd_mux[CNT_W-1:0] = cmp_vals[0];
        OFS_CMPB: rd_mux[CNT_W-1:0] = cmp_vals[1];
        OFS_CMPC: rd_mux[CNT_W-1:0] = cmp_vals[2];
        OFS_STAT: begin
          rd_mux[0]  = sts_q.ovf;
          rd_mux[2]  = sts_q.cmp_a;
          rd_mux[3]  = sts_q.cmp_b;
          rd_mux[4]  = sts_q.cmp_c;
          rd_mux[16] = clk_on;
          rd_mux[17] = pin;
        end
        OFS_IMSK: begin
          rd_mux[0] = msk_q.ovf;
          rd_mux[2] = msk_q.cmp_a;
          rd_mux[3] = msk_q.cmp_b;
          rd_mux[4] = msk_q.cmp_c;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign irq = |(sts_q & msk_q);
endmodule

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  ctl_en,
  input  logic                  ctl_dis,
  input  logic                  ctl_trg,
  input  mode_t                 mode,
  input  logic [2:0][CNT_W-1:0] cmp_vals,
  output logic [CNT_W-1:0]      cnt,
  output logic                  clk_on,
  output evt_t                  evt
);
  localparam int N_CMP = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q;
  logic             adv;
  logic [N_CMP-1:0] hit;
  logic             c_reset;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign hit[g] = (cnt == cmp_vals[g]);
  end

  assign adv     = clk_on && run_q && tick && !ctl_trg;
  assign c_reset = mode.auto_rst && hit[2];

  assign evt.cmp_a = adv && hit[0];
  assign evt.cmp_b = adv && hit[1];
  assign evt.cmp_c = adv && hit[2];
  assign evt.ovf   = adv && (cnt == CNT_MAX) && !c_reset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctl_trg) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= c_reset ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (ctl_trg) begin
      run_q <= 1'b1;
    end else if (evt.cmp_c && (mode.stop_on_c || mode.dis_on_c)) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_on <= 1'b0;
    end else if (ctl_dis) begin
      clk_on <= 1'b0;
    end else if (ctl_en) begin
      clk_on <= 1'b1;
    end else if (evt.cmp_c && mode.dis_on_c) begin
      clk_on <= 1'b0;
    end
  end
endmodule

// File: rtl/wt_wave.sv
module wt_wave
  import wt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  evt_t  evt,
  input  mode_t mode,
  output logic  pin
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else if (evt.cmp_c) begin
      pin <= apply_act(mode.act_c, pin);
    end else if (evt.cmp_a) begin
      pin <= apply_act(mode.act_a, pin);
    end
  end
endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick,
  output logic [CNT_W-1:0]  count_val,
  output logic              tioa_o,
  output logic              irq_o
);
  mode_t                 mode;
  evt_t                  evt;
  logic [2:0][CNT_W-1:0] cmp_vals;
  logic                  ctl_en, ctl_dis, ctl_trg;
  logic                  clk_on;

  wt_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_IDX(CHAN_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt(evt), .clk_on(clk_on), .pin(tioa_o), .cnt(count_val),
    .mode(mode), .cmp_vals(cmp_vals),
    .ctl_en(ctl_en), .ctl_dis(ctl_dis), .ctl_trg(ctl_trg),
    .irq(irq_o)
  );

  wt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctl_en(ctl_en), .ctl_dis(ctl_dis), .ctl_trg(ctl_trg),
    .mode(mode), .cmp_vals(cmp_vals),
    .cnt(count_val), .clk_on(clk_on), .evt(evt)
  );

  wt_wave u_wave (
    .clk(clk), .rst_n(rst_n), .evt(evt), .mode(mode), .pin(tioa_o)
  );
endmodule

// File: rtl/wt_chk.sv
module wt_chk
  import wt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CHAN_IDX = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              tick,
  input logic [CNT_W-1:0]  count_val,
  input logic              tioa_o,
  input logic              irq_o,
  input logic              clk_on,
  input evt_t              evt,
  input mode_t             mode
);
  localparam int BANK_W = ADDR_W - BANK_LSB;
  localparam logic [BANK_W-1:0] BANK_ID = BANK_W'(CHAN_IDX);

  logic in_bank, wr_ctl, wr_idis;
  assign in_bank = reg_wr && (reg_addr[ADDR_W-1:BANK_LSB] == BANK_ID);
  assign wr_ctl  = in_bank && (reg_addr[BANK_LSB-1:0] == OFS_CTRL);
  assign wr_idis = in_bank && (reg_addr[BANK_LSB-1:0] == OFS_IDIS);

  assert_dis_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && reg_wdata[1]) |=> !clk_on);

  assert_trig_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && reg_wdata[2]) |=> (count_val == '0));

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr_ctl && reg_wdata[2])) |=> $stable(count_val));

  assert_dis_on_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.cmp_c && mode.dis_on_c && !wr_ctl) |=> !clk_on);

  assert_pin_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tioa_o) |-> $past(evt.cmp_a || evt.cmp_c));

  assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idis && reg_wdata[0] && reg_wdata[2] && reg_wdata[3] && reg_wdata[4])
      |=> !irq_o);
endmodule

bind wave_timer_chan wt_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_IDX(CHAN_IDX)
) u_wt_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tick(tick), .count_val(count_val),
  .tioa_o(tioa_o), .irq_o(irq_o), .clk_on(clk_on), .evt(evt), .mode(mode)
);

// File: tb/test_wave_timer_chan.sv
module test_wave_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, tick = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] count_val;
  logic        tioa_o, irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wave_timer_chan i_wave_timer_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick(tick), .count_val(count_val), .tioa_o(tioa_o), .irq_o(irq_o)
  );

  // reference state
  logic [15:0] m_cnt, m_a, m_b, m_c;
  logic        m_run, m_clk, m_pin;
  logic [4:0]  m_sts, m_msk;        // bit positions 0,2,3,4 used
  logic        m_stop, m_dis, m_auto;
  logic [1:0]  m_acta, m_actc;
  logic [31:0] m_rdata;

  function automatic logic act_f(input logic [1:0] a, input logic cur);
    case (a)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] stat_word();
    return {14'b0, m_pin, m_clk, 11'b0, m_sts[4:2], 1'b0, m_sts[0]};
  endfunction

  function automatic logic [31:0] mode_word();
    return {12'b0, m_actc, m_acta, 1'b0, m_auto, 6'b0, m_dis, m_stop, 6'b0};
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a[7:6] != 2'b00) return "R9";
    case (a[5:0])
      6'h20: return "R7";
      6'h2c: return "R8";
      6'h04: return "R10 mode";
      6'h10: return "R10 count";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_a = '0; m_b = '0; m_c = '0;
    m_run = 0; m_clk = 0; m_pin = 0; m_sts = '0; m_msk = '0;
    m_stop = 0; m_dis = 0; m_auto = 0; m_acta = '0; m_actc = '0;
    m_rdata = '0;
  endtask

  // one clock: drive at negedge, predict, wait an edge, compare at next negedge
  task automatic cyc(input logic wr, input logic rd, input logic [7:0] ad,
                     input logic [31:0] wd, input logic tk);
    logic sel, wc, en, dis, trg, adv, hitc, ea, eb, ec, eo;
    logic [15:0] cnt_n; logic run_n, clk_n, pin_n;
    logic [4:0] sts_n, msk_n, wm; logic [31:0] rd_n;
    reg_wr = wr; reg_rd = rd; reg_addr = ad; reg_wdata = wd; tick = tk;
    sel = (ad[7:6] == 2'b00);
    wc  = wr && sel && ad[5:0] == 6'h00;
    en = wc && wd[0]; dis = wc && wd[1]; trg = wc && wd[2];
    adv  = m_clk && m_run && tk && !trg;
    hitc = (m_cnt == m_c);
    ea = adv && m_cnt == m_a; eb = adv && m_cnt == m_b; ec = adv && hitc;
    eo = adv && m_cnt == 16'hFFFF && !(m_auto && hitc);
    cnt_n = trg ? 16'h0 : adv ? ((m_auto && hitc) ? 16'h0 : m_cnt + 16'd1) : m_cnt;
    run_n = trg ? 1'b1 : (ec && (m_stop || m_dis)) ? 1'b0 : m_run;
    clk_n = dis ? 1'b0 : en ? 1'b1 : (ec && m_dis) ? 1'b0 : m_clk;
    pin_n = ec ? act_f(m_actc, m_pin) : ea ? act_f(m_acta, m_pin) : m_pin;
    sts_n = ((rd && sel && ad[5:0] == 6'h20) ? 5'b0 : m_sts) | {ec, eb, ea, 1'b0, eo};
    wm = {wd[4:2], 1'b0, wd[0]};
    msk_n = m_msk;
    rd_n  = m_rdata;
    if (rd) begin
      rd_n = '0;
      if (sel) case (ad[5:0])
        6'h04: rd_n = mode_word();
        6'h10: rd_n = {16'b0, m_cnt};
        6'h14: rd_n = {16'b0, m_a};
        6'h18: rd_n = {16'b0, m_b};
        6'h1c: rd_n = {16'b0, m_c};
        6'h20: rd_n = stat_word();
        6'h2c: rd_n = {27'b0, m_msk};
        default: ;
      endcase
    end
    if (wr && sel) case (ad[5:0])
      6'h04: begin
        m_stop = wd[6]; m_dis = wd[7]; m_auto = wd[14];
        m_acta = wd[17:16]; m_actc = wd[19:18];
      end
      6'h14: m_a = wd[15:0];
      6'h18: m_b = wd[15:0];
      6'h1c: m_c = wd[15:0];
      6'h24: msk_n = m_msk | wm;
      6'h28: msk_n = m_msk & ~wm;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    m_cnt = cnt_n; m_run = run_n; m_clk = clk_n; m_pin = pin_n;
    m_sts = sts_n; m_msk = msk_n; m_rdata = rd_n;
    chk("R3 R4 count", {16'b0, count_val}, {16'b0, m_cnt});
    chk("R6 pin", {31'b0, tioa_o}, {31'b0, m_pin});
    chk("R8 irq", {31'b0, irq_o}, {31'b0, |(m_sts & m_msk)});
    if (rd) chk(tag_of(ad), reg_rdata, m_rdata);
    reg_wr = 0; reg_rd = 0; tick = 0;
  endtask

  task automatic wr_reg(input logic [7:0] ad, input logic [31:0] wd);
    cyc(1'b1, 1'b0, ad, wd, 1'b0);
  endtask
  task automatic rd_reg(input logic [7:0] ad);
    cyc(1'b0, 1'b1, ad, 32'h0, 1'b0);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] ad;
    logic [31:0] wd;
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 count", {16'b0, count_val}, 32'h0);
    chk("R1 pin", {31'b0, tioa_o}, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd_reg(8'h20); chk("R1 status", reg_rdata, 32'h0);
    rd_reg(8'h04); chk("R1 mode", reg_rdata, 32'h0);

    // R2: enable and disable together, disable wins
    wr_reg(8'h00, 32'h3);
    rd_reg(8'h20); chk("R2 clock off", reg_rdata, 32'h0);
    wr_reg(8'h00, 32'h1);
    rd_reg(8'h20); chk("R2 clock on", reg_rdata, 32'h0001_0000);

    // R5: one-shot, stop on C with auto-reset
    wr_reg(8'h04, 32'h0000_4040);
    wr_reg(8'h1c, 32'd3);
    wr_reg(8'h00, 32'h5);
    ticks(10);
    chk("R5 stopped count", {16'b0, count_val}, 32'h0);
    rd_reg(8'h20); chk("R5 stop keeps clock", reg_rdata, 32'h0001_001C);
    // R5: disable-on-C variant
    wr_reg(8'h04, 32'h0000_40C0);
    wr_reg(8'h00, 32'h5);
    ticks(10);
    rd_reg(8'h20); chk("R5 disable clears clock", reg_rdata, 32'h0000_001C);

    // R6: set on A, clear on C
    wr_reg(8'h04, 32'h0009_4000);
    wr_reg(8'h14, 32'd1);
    wr_reg(8'h1c, 32'd2);
    wr_reg(8'h00, 32'h5);
    ticks(2);
    chk("R6 set on A", {31'b0, tioa_o}, 32'h1);
    ticks(1);
    chk("R6 clear on C", {31'b0, tioa_o}, 32'h0);
    // R6: same-tick A and C, C action wins (A set, C clear)
    wr_reg(8'h14, 32'd2);
    wr_reg(8'h00, 32'h4);
    ticks(3);
    chk("R6 C priority", {31'b0, tioa_o}, 32'h0);

    // R8: mask enables interrupt, disable removes it
    wr_reg(8'h24, 32'h10);
    ticks(3);
    chk("R8 irq on", {31'b0, irq_o}, 32'h1);
    rd_reg(8'h2c); chk("R8 mask read", reg_rdata, 32'h10);
    wr_reg(8'h28, 32'h1D);
    chk("R8 irq off", {31'b0, irq_o}, 32'h0);

    // R9: foreign-bank write and read have no effect
    wr_reg(8'h5c, 32'd7);
    rd_reg(8'h1c); chk("R9 foreign write", reg_rdata, 32'd2);
    rd_reg(8'h60); chk("R9 foreign read", reg_rdata, 32'h0);

    // R4: free-running wrap and overflow flag
    wr_reg(8'h04, 32'h0);
    wr_reg(8'h20, 32'h0);
    rd_reg(8'h20);
    wr_reg(8'h00, 32'h5);
    ticks(65536);
    chk("R4 wrap", {16'b0, count_val}, 32'h0);
    rd_reg(8'h20); chk("R4 overflow flag", reg_rdata[0], 32'h1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic dowr, dord;
      int k;
      k = $urandom_range(0, 9);
      dowr = 0; dord = 0;
      if (k < 2) dowr = 1; else if (k < 4) dord = 1;
      case ($urandom_range(0, 9))
        0: ad = 8'h00; 1: ad = 8'h04; 2: ad = 8'h10; 3: ad = 8'h14;
        4: ad = 8'h18; 5: ad = 8'h1c; 6: ad = 8'h20; 7: ad = 8'h24;
        8: ad = 8'h28; default: ad = 8'h2c;
      endcase
      if ($urandom_range(0, 15) == 0) ad[7:6] = 2'($urandom_range(1, 3));
      case (ad[5:0])
        6'h00: wd = {29'b0, $urandom_range(0, 3) == 0,
                     $urandom_range(0, 7) == 0, $urandom_range(0, 3) != 0};
        6'h04: wd = $urandom & 32'h000F_60C0;
        6'h14, 6'h18, 6'h1c: wd = 32'($urandom_range(0, 24));
        default: wd = $urandom & 32'h1F;
      endcase
      cyc(dowr, dord, ad, wd, $urandom_range(0, 1) == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule